// File: doc/BRIEF.md
# Coprocessor Status and Control Register with Semaphore

This block holds the run and status state of a coprocessor and gives a host processor a single status word to control it. A host write to the status address carries pairs of command bits: one bit of each pair clears a flag, the other sets it. The flags are the halt state, the interrupt-on-break enable, the interrupt line, and eight software signal flags. A further write bit clears the break flag. A pair whose two bits are both 1 leaves its flag alone. Each pair acts on its own, so one write can start the core, set some signals, clear others and acknowledge the interrupt.

The coprocessor core reports two events. A break event sets both the break flag and the halt flag. It also raises the interrupt line when interrupt-on-break is enabled. A self-halt event sets only the halt flag. The DMA front end drives busy and full levels, and the status word reports them as they stand. A second address holds a hardware semaphore. Reading it when it is free returns 0 and takes it. Reading it while it is taken returns 1. Any write to that address frees it.

Reads are registered. The data and a valid strobe appear one cycle after the read request, and they show the state from before any update made in the request cycle.

Top module: `cosr_ctl`

## Requirements
- R1: After reset, halted is 1. Broke, the interrupt-on-break enable, the interrupt output, all eight signals and the semaphore are 0.
- R2: A status read returns halted in bit 0, broke in bit 1, DMA busy in bit 2, DMA full in bit 3, the interrupt-on-break enable in bit 6 and signals 0..7 in bits 7..14. All other bits read 0.
- R3: In a status write, bit 0 clears halted and bit 1 sets it. When both bits are 1, halted does not change.
- R4: In a status write, bit 2 clears the broke flag.
- R5: In a status write, bit 3 clears the interrupt output and bit 4 sets it. When both bits are 1, the interrupt does not change.
- R6: In a status write, bit 7 clears the interrupt-on-break enable and bit 8 sets it. When both bits are 1, the enable does not change.
- R7: In a status write, bit 9+2n clears signal n and bit 10+2n sets it, for n = 0..7. When both bits of a pair are 1, that signal does not change. Each pair acts independently of the other pairs.
- R8: A break event sets both broke and halted. A self-halt event sets halted and leaves broke unchanged.
- R9: A break event sets the interrupt output when the interrupt-on-break enable is 1, and leaves it unchanged when the enable is 0.
- R10: A read of the semaphore address returns 0 and takes the semaphore when it is free. It returns 1 when the semaphore is already taken.
- R11: Any write to the semaphore address frees the semaphore, whatever the data. A write to the status address does not touch the semaphore.
- R12: rd_valid is 1 exactly in the cycle after a read request, with rdata valid in that cycle. In every other cycle rd_valid is 0.
- R13: A core event in the same cycle as a host write that clears halted wins: halted ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Register select (status or semaphore) |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| brk_evt | input | 1 | Break event pulse from the core |
| self_halt_evt | input | 1 | Self-halt event pulse from the core |
| dma_busy | input | 1 | DMA engine busy level |
| dma_full | input | 1 | DMA request queue full level |
| halted | output | 1 | Core halted (core runs while 0) |
| irq | output | 1 | Interrupt request line |

## Verification
The bench writes both bits of every pair: halt, interrupt, enable, and one signal mixed with live pairs for other signals. A decoder that gives one bit of a pair priority would visibly set or clear the flag. It fires a break event with the enable both on and off, to catch an interrupt raised without regard to the enable, and a self-halt that must leave broke alone. It pushes a break event into the same cycle as a host start command, which a host-wins design would leave running. It reads the semaphore repeatedly and writes the status address in between, which exposes a lock that never grants, never holds, or is freed by the wrong address.

// File: rtl/cosr_pkg.sv
package cosr_pkg;

  // Read-side bit positions of the status word
  localparam int RD_HALT  = 0;
  localparam int RD_BROKE = 1;
  localparam int RD_BUSY  = 2;
  localparam int RD_FULL  = 3;
  localparam int RD_IE    = 6;
  localparam int RD_SIG   = 7;

  // Write-side command bit positions
  localparam int WR_RUN    = 0;
  localparam int WR_STOP   = 1;
  localparam int WR_UNBRK  = 2;
  localparam int WR_IACK   = 3;
  localparam int WR_IRAISE = 4;
  localparam int WR_IE_OFF = 7;
  localparam int WR_IE_ON  = 8;
  localparam int WR_SIG    = 9;

  // One clear/set command pair
  typedef struct packed {
    logic clr;
    logic set;
  } pair_t;

  // Resolve a pair against the current value; both asserted means hold
  function automatic logic pair_resolve(input pair_t p, input logic cur);
    logic r;
    r = cur;
    if (p.set && !p.clr) r = 1'b1;
    else if (p.clr && !p.set) r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/cosr_flag.sv
module cosr_flag
  import cosr_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_en,
  input  pair_t cmd,
  input  logic  force_set,
  output logic  q
);

  logic q_r;
  logic q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (cmd_en) q_nxt = pair_resolve(cmd, q_r);
    if (force_set) q_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= RST_VAL;
    else     q_r <= q_nxt;
  end

  assign q = q_r;

  // R3 R5 R6 R7: a pair with both bits set and no event leaves the flag alone
  p_pair_both_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd.clr && cmd.set && !force_set) |=> $stable(q_r));

  // R8: an event forces the flag high on the next cycle
  p_force_sets_r8: assert property (@(posedge clk) disable iff (rst)
    force_set |=> q_r);

endmodule

// File: rtl/cosr_sig_bank.sv
module cosr_sig_bank
  import cosr_pkg::*;
#(
  parameter int NUM_SIG = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_en,
  input  logic [2*NUM_SIG-1:0]   cmd_bits,
  output logic [NUM_SIG-1:0]     sig
);

  for (genvar n = 0; n < NUM_SIG; n++) begin : g_sig
    pair_t cmd_n;
    assign cmd_n.clr = cmd_bits[2*n];
    assign cmd_n.set = cmd_bits[2*n+1];

    cosr_flag #(.RST_VAL(1'b0)) u_flag (
      .clk       (clk),
      .rst       (rst),
      .cmd_en    (cmd_en),
      .cmd       (cmd_n),
      .force_set (1'b0),
      .q         (sig[n])
    );
  end

endmodule

// File: rtl/cosr_sem.sv
module cosr_sem (
  input  logic clk,
  input  logic rst,
  input  logic acquire,
  input  logic release_req,
  output logic taken
);

  logic taken_r;

  always_ff @(posedge clk) begin
    if (rst)              taken_r <= 1'b0;
    else if (release_req) taken_r <= 1'b0;
    else if (acquire)     taken_r <= 1'b1;
  end

  assign taken = taken_r;

  // R11: a release always frees the lock
  p_release_frees_r11: assert property (@(posedge clk) disable iff (rst)
    release_req |=> !taken_r);

  // R10: once taken, only a release frees it
  p_held_until_release_r10: assert property (@(posedge clk) disable iff (rst)
    (taken_r && !release_req) |=> taken_r);

endmodule

// File: rtl/cosr_ctl.sv
module cosr_ctl
  import cosr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int NUM_SIG   = 8,
  parameter int STAT_ADDR = 0,
  parameter int SEM_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic              brk_evt,
  input  logic              self_halt_evt,
  input  logic              dma_busy,
  input  logic              dma_full,
  output logic              halted,
  output logic              irq
);

  localparam int SIG_CMD_W = 2 * NUM_SIG;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_SEM  = ADDR_W'(SEM_ADDR);

  // Mask of the write bits that carry a command
  localparam logic [DATA_W-1:0] CMD_MASK =
      (DATA_W'(1) << WR_RUN) | (DATA_W'(1) << WR_STOP) | (DATA_W'(1) << WR_UNBRK) |
      (DATA_W'(1) << WR_IACK) | (DATA_W'(1) << WR_IRAISE) |
      (DATA_W'(1) << WR_IE_OFF) | (DATA_W'(1) << WR_IE_ON) |
      (((DATA_W'(1) << SIG_CMD_W) - DATA_W'(1)) << WR_SIG);

  // Address decode
  logic stat_wr, stat_rd, sem_wr, sem_rd;
  assign stat_wr = wr_en && (addr == A_STAT);
  assign stat_rd = rd_en && (addr == A_STAT);
  assign sem_wr  = wr_en && (addr == A_SEM);
  assign sem_rd  = rd_en && (addr == A_SEM);

  // Command pairs
  pair_t halt_cmd, brk_cmd, irq_cmd, ie_cmd;
  assign halt_cmd.clr = wdata[WR_RUN];
  assign halt_cmd.set = wdata[WR_STOP];
  assign brk_cmd.clr  = wdata[WR_UNBRK];
  assign brk_cmd.set  = 1'b0;
  assign irq_cmd.clr  = wdata[WR_IACK];
  assign irq_cmd.set  = wdata[WR_IRAISE];
  assign ie_cmd.clr   = wdata[WR_IE_OFF];
  assign ie_cmd.set   = wdata[WR_IE_ON];

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~CMD_MASK);

  // Flag state
  logic halted_q, broke_q, ie_q, irq_q, sem_q;
  logic [NUM_SIG-1:0] sig_q;

  cosr_flag #(.RST_VAL(1'b1)) u_halt (
    .clk(clk), .rst(rst), .cmd_en(stat_wr), .cmd(halt_cmd),
    .force_set(brk_evt | self_halt_evt), .q(halted_q)
  );

  cosr_flag #(.RST_VAL(1'b0)) u_broke (
    .clk(clk), .rst(rst), .cmd_en(stat_wr), .cmd(brk_cmd),
    .force_set(brk_evt), .q(broke_q)
  );

  cosr_flag #(.RST_VAL(1'b0)) u_ie (
    .clk(clk), .rst(rst), .cmd_en(stat_wr), .cmd(ie_cmd),
    .force_set(1'b0), .q(ie_q)
  );

  cosr_flag #(.RST_VAL(1'b0)) u_irq (
    .clk(clk), .rst(rst), .cmd_en(stat_wr), .cmd(irq_cmd),
    .force_set(brk_evt & ie_q), .q(irq_q)
  );

  cosr_sig_bank #(.NUM_SIG(NUM_SIG)) u_sig (
    .clk(clk), .rst(rst), .cmd_en(stat_wr),
    .cmd_bits(wdata[WR_SIG +: SIG_CMD_W]), .sig(sig_q)
  );

  cosr_sem u_sem (
    .clk(clk), .rst(rst), .acquire(sem_rd), .release_req(sem_wr), .taken(sem_q)
  );

  // Packed status word
  logic [DATA_W-1:0] status_word;
  always_comb begin
    status_word = '0;
    status_word[RD_HALT]  = halted_q;
    status_word[RD_BROKE] = broke_q;
    status_word[RD_BUSY]  = dma_busy;
    status_word[RD_FULL]  = dma_full;
    status_word[RD_IE]    = ie_q;
    status_word[RD_SIG +: NUM_SIG] = sig_q;
  end

  // Registered read port
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (stat_rd)     rdata_q <= status_word;
      else if (sem_rd) rdata_q <= DATA_W'(sem_q);
      else             rdata_q <= '0;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;
  assign halted   = halted_q;
  assign irq      = irq_q;

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (halted && !irq && !broke_q && !ie_q && sig_q == '0 && !sem_q));

  // R8: a break event sets both halted and broke
  p_break_halts_r8: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> (halted && broke_q));

  // R9: an enabled break raises the interrupt
  p_break_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && ie_q) |=> irq);

  // R9: with the enable off, no write and a break, irq holds
  p_break_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && !ie_q && !stat_wr) |=> $stable(irq));

  // R10: a read of a free semaphore returns 0
  p_sem_grant_r10: assert property (@(posedge clk) disable iff (rst)
    (sem_rd && !sem_q) |=> (rd_valid && rdata == '0));

  // R10: a read of a taken semaphore returns 1
  p_sem_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (sem_rd && sem_q) |=> (rd_valid && rdata == DATA_W'(1)));

  // R12: valid follows the request by exactly one cycle
  p_rvalid_timing_r12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R13: an event beats a host start in the same cycle
  p_event_beats_start_r13: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata[WR_RUN] && (brk_evt || self_halt_evt)) |=> halted);

endmodule

// File: tb/sim_cosr_ctl.sv
module sim_cosr_ctl;

  localparam int DW = 32;
  localparam int AW = 2;
  localparam int A_STAT = 0;
  localparam int A_SEM  = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rd_valid;
  logic          brk_evt = 1'b0, self_halt_evt = 1'b0;
  logic          dma_busy = 1'b0, dma_full = 1'b0;
  logic          halted, irq;

  always #10 clk = ~clk;  // 50 MHz

  cosr_ctl #(.DATA_W(DW), .ADDR_W(AW), .NUM_SIG(8), .STAT_ADDR(A_STAT), .SEM_ADDR(A_SEM)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .brk_evt(brk_evt), .self_halt_evt(self_halt_evt),
    .dma_busy(dma_busy), .dma_full(dma_full), .halted(halted), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  // Expected status word built from the R2 layout
  function automatic logic [DW-1:0] stw(input logic h, input logic b, input logic busy,
                                        input logic full, input logic ie, input logic [7:0] s);
    return DW'(h) | (DW'(b) << 1) | (DW'(busy) << 2) | (DW'(full) << 3) |
           (DW'(ie) << 6) | (DW'(s) << 7);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected reads as the design returns them (R12)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 unexpected rd_valid actual=1 expected=0");
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_evt = 1'b1;
    @(negedge clk); brk_evt = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 halted", DW'(halted), DW'(1));
    check("R1 irq", DW'(irq), DW'(0));
    check("R12 idle rd_valid", DW'(rd_valid), DW'(0));
    rd(A_STAT, stw(1,0,0,0,0,8'h00), "R1 status after reset");
    rd(A_SEM, DW'(0), "R1 semaphore free after reset");
    wr(A_SEM, DW'(0));

    // R2 DMA levels
    dma_busy = 1'b1;
    rd(A_STAT, stw(1,0,1,0,0,8'h00), "R2 busy bit");
    dma_busy = 1'b0; dma_full = 1'b1;
    rd(A_STAT, stw(1,0,0,1,0,8'h00), "R2 full bit");
    dma_full = 1'b0;

    // R3 halt pair
    wr(A_STAT, 32'h1);
    check("R3 start clears halted", DW'(halted), DW'(0));
    wr(A_STAT, 32'h3);
    check("R3 both bits keep running", DW'(halted), DW'(0));
    wr(A_STAT, 32'h2);
    check("R3 stop sets halted", DW'(halted), DW'(1));
    wr(A_STAT, 32'h3);
    check("R3 both bits keep halted", DW'(halted), DW'(1));
    wr(A_STAT, 32'h1);

    // R8 break and R4 clear broke
    pulse_brk();
    check("R8 break halts", DW'(halted), DW'(1));
    check("R9 masked break no irq", DW'(irq), DW'(0));
    rd(A_STAT, stw(1,1,0,0,0,8'h00), "R8 break sets broke");
    wr(A_STAT, 32'h4);
    rd(A_STAT, stw(1,0,0,0,0,8'h00), "R4 broke cleared");
    wr(A_STAT, 32'h1);
    @(negedge clk); self_halt_evt = 1'b1;
    @(negedge clk); self_halt_evt = 1'b0;
    rd(A_STAT, stw(1,0,0,0,0,8'h00), "R8 self-halt leaves broke 0");

    // R5 interrupt pair
    wr(A_STAT, 32'h10);
    check("R5 raise", DW'(irq), DW'(1));
    wr(A_STAT, 32'h18);
    check("R5 both bits keep 1", DW'(irq), DW'(1));
    wr(A_STAT, 32'h8);
    check("R5 ack", DW'(irq), DW'(0));
    wr(A_STAT, 32'h18);
    check("R5 both bits keep 0", DW'(irq), DW'(0));

    // R6 enable pair and R9 break interrupt
    wr(A_STAT, 32'h100);
    rd(A_STAT, stw(1,0,0,0,1,8'h00), "R6 enable set");
    wr(A_STAT, 32'h180);
    rd(A_STAT, stw(1,0,0,0,1,8'h00), "R6 both bits keep enable");
    pulse_brk();
    check("R9 enabled break raises irq", DW'(irq), DW'(1));
    wr(A_STAT, 32'hC);
    check("R5 ack after break", DW'(irq), DW'(0));
    wr(A_STAT, 32'h80);
    rd(A_STAT, stw(1,0,0,0,0,8'h00), "R6 enable cleared");
    wr(A_STAT, 32'h180);
    rd(A_STAT, stw(1,0,0,0,0,8'h00), "R6 both bits keep disabled");
    pulse_brk();
    check("R9 disabled break no irq", DW'(irq), DW'(0));
    wr(A_STAT, 32'h4);

    // R7 signals: set all (bits 10,12,...,24)
    wr(A_STAT, 32'h0155_5400);
    rd(A_STAT, stw(1,0,0,0,0,8'hFF), "R7 set all signals");
    // clear signal 0 (bit 9) and signal 3 (bit 15)
    wr(A_STAT, 32'h0000_8200);
    rd(A_STAT, stw(1,0,0,0,0,8'hF6), "R7 clear signals 0 and 3");
    // set signal 0 (bit 10), both bits of signal 1 (bits 11,12)
    wr(A_STAT, 32'h0000_1C00);
    rd(A_STAT, stw(1,0,0,0,0,8'hF7), "R7 both bits hold signal 1");
    // clear signal 7 (bit 23), both bits of signal 4 (bits 17,18)
    wr(A_STAT, 32'h0086_0000);
    rd(A_STAT, stw(1,0,0,0,0,8'h77), "R7 hold signal 4 clear signal 7");

    // R13 event beats host start
    wr(A_STAT, 32'h1);
    check("R13 running before race", DW'(halted), DW'(0));
    @(negedge clk); wr_en = 1'b1; addr = AW'(A_STAT); wdata = 32'h1; brk_evt = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0; brk_evt = 1'b0;
    check("R13 break wins over start", DW'(halted), DW'(1));
    wr(A_STAT, 32'h4);

    // R10 / R11 semaphore
    rd(A_SEM, DW'(0), "R10 first read grants");
    rd(A_SEM, DW'(1), "R10 second read taken");
    wr(A_STAT, 32'h0);
    rd(A_SEM, DW'(1), "R11 status write leaves lock");
    wr(A_SEM, 32'hDEAD_BEEF);
    rd(A_SEM, DW'(0), "R11 write frees lock");
    rd(A_SEM, DW'(1), "R10 retaken");

    repeat (3) @(negedge clk);
    check("R12 idle rd_valid at end", DW'(rd_valid), DW'(0));
    check("R12 all reads returned", DW'(exp_q.size()), DW'(0));
    summary();
  end

endmodule